// File: doc/BRIEF.md
# SDRAM Column Burst Sequencer

This block is the column-access engine on the device side of a synchronous DRAM. After a row is open, a registered READ or WRITE command supplies a starting column. The block then walks the burst: it produces the storage-array column for every beat, captures write data from the data bus on each write beat, and drives read data back through a latency pipeline. It raises the output enable only while read beats are valid.

Two features change the plain burst. A clock-enable input can freeze the internal clock part-way through a burst. When the enable is sampled low on an edge, the next internal edge is dropped: the column counter stops, the read data already on the bus stays driven, and commands and write data present on the dropped edge are ignored. A single-write mode makes every WRITE touch exactly one column, while READs keep the programmed length and ordering.

The controller FSM has three states. S_IDLE has no burst active. S_RD fetches read beats. S_WR stores write beats. A READ accepted in any state goes to S_RD. A WRITE accepted in any state stays in S_IDLE when the burst is one column long, and goes to S_WR otherwise. S_RD and S_WR return to S_IDLE after their last beat. A full-page burst never has a last beat, so only a new command ends it. All transitions happen only on internal edges that are not suspended.

Top module: `sdb_col_burst`

## Requirements
- R1: While reset is asserted and on the first cycle after it, dq_oe, arr_rd and arr_wr are low.
- R2: With a latency of 2, beat k of a READ accepted on edge T is on dq_out with dq_oe high from edge T+1+k until edge T+2+k. Each beat carries the array word at that beat's column.
- R3: bl_code 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8; codes 4 to 6 give a burst of one. With ilv_mode low, beat i uses the aligned block base plus ((start mod len) + i) mod len. With ilv_mode high, beat i uses start XOR i.
- R4: bl_code 7 selects a full-page burst. It always counts sequentially, wraps from the top column to column 0, and continues until a new command arrives.
- R5: A WRITE writes beat 0 at col_in with dq_in on the edge the command is accepted. Each later beat k writes on the k-th internal edge after that. arr_rd and arr_wr are never high together.
- R6: With wr_single high, a WRITE writes exactly one column whatever bl_code says. READs keep their programmed length and ordering.
- R7: A READ or WRITE accepted during a burst ends the old burst on that edge and starts the new one. A WRITE also discards read beats not yet delivered.
- R8: When cke is sampled low on an edge, the next edge is suspended. dq_out and dq_oe hold their values and the burst column does not advance.
- R9: A command and the dq_in data present on a suspended edge are ignored, and no array write happens on that edge.
- R10: Once cke is sampled high again, the burst resumes on the next edge from the beat where it stopped.
- R11: dq_oe falls one cycle after the last read beat, unless a suspend holds that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low suspends the next internal edge |
| cmd_rd | input | 1 | Registered READ command (wins over cmd_wr) |
| cmd_wr | input | 1 | Registered WRITE command |
| col_in | input | COL_W | Starting column for the command |
| bl_code | input | 3 | Burst-length code (0..3 = 1/2/4/8, 7 = full page) |
| ilv_mode | input | 1 | 1 = interleaved order, 0 = sequential |
| wr_single | input | 1 | 1 = every WRITE is a single column |
| dq_in | input | DW | Write data from the bus |
| dq_out | output | DW | Read data to the bus |
| dq_oe | output | 1 | Read data valid / bus drive enable |
| arr_col | output | COL_W | Array column of the current beat |
| arr_rd | output | 1 | Array read strobe |
| arr_wr | output | 1 | Array write strobe (already gated by suspend) |
| arr_wdata | output | DW | Array write data |
| arr_rdata | input | DW | Array read data for arr_col |

## Verification
Write beats are combinational. Beat 0 of a WRITE shows on arr_wr, arr_col and arr_wdata in the same cycle as the command, and each later beat shows one cycle further on. The bench reads these a moment after it drives the inputs. Read beat k shows on dq_out one register after its fetch, so it is due in the cycle following edge T+1+k. The bench skips exactly that many falling edges after the command before it compares. Each suspended edge delays every later beat by one cycle, and the directed suspend tests add that cycle to the expected timing. They also check that the held values stay unchanged during the cycle the suspend adds.

// File: rtl/sdb_pkg.sv
`timescale 1ns/1ps
package sdb_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RD   = 2'd1,
        S_WR   = 2'd2
    } sdb_state_t;

    localparam logic [2:0] BL_FULL = 3'd7;

    // true when the code yields a one-column burst (code 0 and reserved codes)
    function automatic logic len_is_one(input logic [2:0] code);
        return !(code == 3'd1 || code == 3'd2 || code == 3'd3 || code == BL_FULL);
    endfunction

endpackage

// File: rtl/sdb_col_gen.sv
`timescale 1ns/1ps
module sdb_col_gen #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] cnt,
    input  logic [2:0]       bl_code,
    input  logic             ilv,
    output logic [COL_W-1:0] col,
    output logic             last
);
    import sdb_pkg::*;

    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] off;
    logic             full;

    always_comb begin
        full = (bl_code == BL_FULL);
        unique case (bl_code)
            3'd1:    mask = COL_W'(1);
            3'd2:    mask = COL_W'(3);
            3'd3:    mask = COL_W'(7);
            BL_FULL: mask = '1;
            default: mask = '0;
        endcase
        off  = (ilv && !full) ? (base ^ cnt) : (base + cnt);
        col  = (base & ~mask) | (off & mask);
        last = !full && (cnt == mask);
    end

endmodule

// File: rtl/sdb_rd_pipe.sv
`timescale 1ns/1ps
module sdb_rd_pipe #(
    parameter int CL = 2,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          flush,
    input  logic          in_v,
    input  logic [DW-1:0] in_d,
    output logic          out_v,
    output logic [DW-1:0] out_d
);
    localparam int DEPTH = CL - 1;

    logic          v [DEPTH];
    logic [DW-1:0] d [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        logic          sv;
        logic [DW-1:0] sd;
        if (g == 0) begin : g_src
            assign sv = in_v;
            assign sd = in_d;
        end else begin : g_src
            assign sv = v[g-1];
            assign sd = d[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  v[g] <= 1'b0;
            else if (en) v[g] <= sv & ~flush;
        end

        always_ff @(posedge clk) begin
            if (en && sv) d[g] <= sd;
        end
    end

    assign out_v = v[DEPTH-1];
    assign out_d = d[DEPTH-1];

endmodule

// File: rtl/sdb_col_burst.sv
`timescale 1ns/1ps
module sdb_col_burst #(
    parameter int COL_W = 8,
    parameter int DW    = 8,
    parameter int CL    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             cmd_rd,
    input  logic             cmd_wr,
    input  logic [COL_W-1:0] col_in,
    input  logic [2:0]       bl_code,
    input  logic             ilv_mode,
    input  logic             wr_single,
    input  logic [DW-1:0]    dq_in,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe,
    output logic [COL_W-1:0] arr_col,
    output logic             arr_rd,
    output logic             arr_wr,
    output logic [DW-1:0]    arr_wdata,
    input  logic [DW-1:0]    arr_rdata
);
    import sdb_pkg::*;

    localparam logic [COL_W-1:0] CNT_ONE = COL_W'(1);

    sdb_state_t       state, nxt_state;
    logic [COL_W-1:0] base, nxt_base;
    logic [COL_W-1:0] cnt, nxt_cnt;
    logic             cke_q;
    logic             ien, rd_go, wr_go, flush;
    logic [COL_W-1:0] burst_col;
    logic             burst_last;

    sdb_col_gen #(.COL_W(COL_W)) u_col (
        .base    (base),
        .cnt     (cnt),
        .bl_code (bl_code),
        .ilv     (ilv_mode),
        .col     (burst_col),
        .last    (burst_last)
    );

    sdb_rd_pipe #(.CL(CL), .DW(DW)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ien),
        .flush (flush),
        .in_v  (arr_rd),
        .in_d  (arr_rdata),
        .out_v (dq_oe),
        .out_d (dq_out)
    );

    // state register: advances only on internal (non-suspended) edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cke_q <= 1'b1;
            state <= S_IDLE;
            base  <= '0;
            cnt   <= '0;
        end else begin
            cke_q <= cke;
            if (cke_q) begin
                state <= nxt_state;
                base  <= nxt_base;
                cnt   <= nxt_cnt;
            end
        end
    end

    // next state and outputs
    always_comb begin
        ien       = cke_q;
        rd_go     = ien & cmd_rd;
        wr_go     = ien & cmd_wr & ~cmd_rd;
        nxt_state = state;
        nxt_base  = base;
        nxt_cnt   = cnt;
        arr_col   = burst_col;
        arr_wr    = 1'b0;
        arr_rd    = (state == S_RD) && !wr_go;
        flush     = wr_go;
        arr_wdata = dq_in;

        if (rd_go) begin
            nxt_state = S_RD;
            nxt_base  = col_in;
            nxt_cnt   = '0;
        end else if (wr_go) begin
            arr_wr  = 1'b1;
            arr_col = col_in;
            nxt_base = col_in;
            nxt_cnt  = CNT_ONE;
            nxt_state = (wr_single || len_is_one(bl_code)) ? S_IDLE : S_WR;
        end else begin
            unique case (state)
                S_IDLE: ;
                S_RD: begin
                    if (burst_last) nxt_state = S_IDLE;
                    else            nxt_cnt   = cnt + CNT_ONE;
                end
                S_WR: begin
                    arr_wr = ien;
                    if (burst_last) nxt_state = S_IDLE;
                    else            nxt_cnt   = cnt + CNT_ONE;
                end
                default: nxt_state = S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sdb_col_burst_chk.sv
`timescale 1ns/1ps
module sdb_col_burst_chk #(
    parameter int DW = 8,
    parameter int CL = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cke,
    input logic          cmd_wr,
    input logic          wr_single,
    input logic          dq_oe,
    input logic [DW-1:0] dq_out,
    input logic          arr_rd,
    input logic          arr_wr,
    input logic [DW-1:0] arr_rdata
);
    logic cke_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cke_d <= 1'b1;
        else        cke_d <= cke;
    end

    // R8
    susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_d |=> $stable(dq_out) && $stable(dq_oe));

    // R9
    susp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_d |-> !arr_wr);

    // R5
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_rd && arr_wr));

    // R6
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_single && arr_wr |=> !arr_wr || cmd_wr || !wr_single);

    if (CL == 2) begin : g_cl2
        // R2
        rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            arr_rd && cke_d |=> dq_oe && dq_out == $past(arr_rdata));

        // R11
        oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cke_d && !arr_rd |=> !dq_oe);
    end

endmodule

bind sdb_col_burst sdb_col_burst_chk #(.DW(DW), .CL(CL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cmd_wr    (cmd_wr),
    .wr_single (wr_single),
    .dq_oe     (dq_oe),
    .dq_out    (dq_out),
    .arr_rd    (arr_rd),
    .arr_wr    (arr_wr),
    .arr_rdata (arr_rdata)
);

// File: tb/tb_sdb_col_burst.sv
`timescale 1ns/1ps
module tb_sdb_col_burst;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       cmd_rd = 1'b0, cmd_wr = 1'b0;
    logic [7:0] col_in = '0;
    logic [2:0] bl_code = '0;
    logic       ilv_mode = 1'b0, wr_single = 1'b0;
    logic [7:0] dq_in = '0;
    logic [7:0] dq_out, arr_col, arr_wdata, arr_rdata;
    logic       dq_oe, arr_rd, arr_wr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] mem [256];

    always #10 clk = ~clk;

    sdb_col_burst #(.COL_W(8), .DW(8), .CL(2)) dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
        .col_in(col_in), .bl_code(bl_code), .ilv_mode(ilv_mode), .wr_single(wr_single),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .arr_col(arr_col),
        .arr_rd(arr_rd), .arr_wr(arr_wr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
    );

    // storage-array model
    assign arr_rdata = mem[arr_col];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 5 + 1);
        end else if (arr_wr) begin
            mem[arr_col] <= arr_wdata;
        end
    end

    // {wr, single, ilv, bl_code[2:0], col[7:0]}
    localparam int NV = 11;
    localparam logic [13:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 3'd2, 8'h05},
        {1'b0, 1'b0, 1'b1, 3'd2, 8'h05},
        {1'b0, 1'b0, 1'b0, 3'd3, 8'h0B},
        {1'b0, 1'b0, 1'b1, 3'd3, 8'h0B},
        {1'b0, 1'b0, 1'b0, 3'd1, 8'h21},
        {1'b0, 1'b0, 1'b0, 3'd0, 8'h33},
        {1'b1, 1'b0, 1'b0, 3'd2, 8'h12},
        {1'b1, 1'b1, 1'b0, 3'd3, 8'h50},
        {1'b0, 1'b1, 1'b0, 3'd2, 8'h12},
        {1'b1, 1'b0, 1'b1, 3'd1, 8'h2D},
        {1'b0, 1'b0, 1'b0, 3'd5, 8'h50}
    };

    function automatic int blen(input logic [2:0] bl);
        if (bl == 3'd7) return 256;
        if (bl >= 3'd1 && bl <= 3'd3) return 1 << bl;
        return 1;
    endfunction

    function automatic logic [7:0] exp_col(input logic [7:0] b, input logic [2:0] bl,
                                           input logic ilv, input int i);
        int len = blen(bl);
        int start = int'(b);
        if (ilv && bl != 3'd7) return 8'(start ^ i);
        return 8'((start - start % len) + ((start % len + i) % len));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [2:0] bl, input logic ilv, input logic sgl);
        bl_code = bl; ilv_mode = ilv; wr_single = sgl;
    endtask

    // R2 R3 R6 R11
    task automatic run_read(input logic [7:0] c, input logic [2:0] bl,
                            input logic ilv, input logic sgl);
        int n = blen(bl);
        @(negedge clk);
        set_mode(bl, ilv, sgl);
        cmd_rd = 1'b1; col_in = c;
        @(negedge clk);
        cmd_rd = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check("R2 oe", int'(dq_oe), 1);
            check("R3 data", int'(dq_out), int'(mem[exp_col(c, bl, ilv, k)]));
        end
        @(negedge clk);
        check("R11 oe release", int'(dq_oe), 0);
    endtask

    // R5 R6 R3
    task automatic run_write(input logic [7:0] c, input logic [2:0] bl,
                             input logic ilv, input logic sgl, input int idx);
        int n = sgl ? 1 : blen(bl);
        @(negedge clk);
        set_mode(bl, ilv, sgl);
        cmd_wr = 1'b1; col_in = c; dq_in = 8'(8'hA0 + idx * 16);
        #1;
        check("R5 beat0 wr", int'(arr_wr), 1);
        check("R5 beat0 col", int'(arr_col), int'(c));
        check("R5 beat0 data", int'(arr_wdata), int'(dq_in));
        @(negedge clk);
        cmd_wr = 1'b0;
        for (int k = 1; k < n; k++) begin
            dq_in = 8'(8'hA0 + idx * 16 + k);
            #1;
            check("R5 beat wr", int'(arr_wr), 1);
            check("R3 write col", int'(arr_col), int'(exp_col(c, bl, ilv, k)));
            @(negedge clk);
        end
        #1;
        check("R6 write end", int'(arr_wr), 0);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 oe in reset", int'(dq_oe), 0);
        check("R1 wr in reset", int'(arr_wr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 oe", int'(dq_oe), 0);
        check("R1 rd", int'(arr_rd), 0);
        check("R1 wr", int'(arr_wr), 0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][13]) run_write(VEC[i][7:0], VEC[i][10:8], VEC[i][11], VEC[i][12], i);
            else            run_read (VEC[i][7:0], VEC[i][10:8], VEC[i][11], VEC[i][12]);
        end

        // R7: read interrupted by read
        @(negedge clk);
        set_mode(3'd3, 1'b0, 1'b0);
        cmd_rd = 1'b1; col_in = 8'h00;
        @(negedge clk);
        cmd_rd = 1'b0;
        @(negedge clk);
        check("R7 A beat0", int'(dq_out), int'(mem[8'h00]));
        cmd_rd = 1'b1; col_in = 8'h44;
        @(negedge clk);
        cmd_rd = 1'b0;
        check("R7 A beat1", int'(dq_out), int'(mem[8'h01]));
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check("R7 B beat", int'(dq_out), int'(mem[exp_col(8'h44, 3'd3, 1'b0, k)]));
        end
        @(negedge clk);
        check("R11 after B", int'(dq_oe), 0);

        // R7: read interrupted by write
        @(negedge clk);
        cmd_rd = 1'b1; col_in = 8'h60;
        @(negedge clk);
        cmd_rd = 1'b0;
        @(negedge clk);
        check("R7 C beat0", int'(dq_out), int'(mem[8'h60]));
        wr_single = 1'b1; cmd_wr = 1'b1; col_in = 8'h70; dq_in = 8'h5A;
        #1;
        check("R7 write accepted", int'(arr_wr), 1);
        @(negedge clk);
        cmd_wr = 1'b0;
        check("R7 read discarded", int'(dq_oe), 0);
        check("R7 write stored", int'(mem[8'h70]), 8'h5A);

        // R4: full page wraps
        @(negedge clk);
        set_mode(3'd7, 1'b1, 1'b0);
        cmd_rd = 1'b1; col_in = 8'hFE;
        @(negedge clk);
        cmd_rd = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check("R4 page beat", int'(dq_out), int'(mem[8'(8'hFE + k)]));
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R4 continues", int'(dq_oe), 1);
        end
        wr_single = 1'b1; cmd_wr = 1'b1; col_in = 8'h80; dq_in = 8'h11;
        @(negedge clk);
        cmd_wr = 1'b0;
        check("R4 terminated", int'(dq_oe), 0);

        // R8 R10: suspend during read
        @(negedge clk);
        set_mode(3'd2, 1'b0, 1'b0);
        cmd_rd = 1'b1; col_in = 8'h04;
        @(negedge clk);
        cmd_rd = 1'b0;
        @(negedge clk);
        check("R8 pre beat0", int'(dq_out), int'(mem[8'h04]));
        cke = 1'b0;
        @(negedge clk);
        check("R8 beat1", int'(dq_out), int'(mem[8'h05]));
        cke = 1'b1;
        @(negedge clk);
        check("R8 held data", int'(dq_out), int'(mem[8'h05]));
        check("R8 held oe", int'(dq_oe), 1);
        @(negedge clk);
        check("R10 beat2", int'(dq_out), int'(mem[8'h06]));
        @(negedge clk);
        check("R10 beat3", int'(dq_out), int'(mem[8'h07]));
        @(negedge clk);
        check("R11 after suspend", int'(dq_oe), 0);

        // R9 R10: suspend during write
        @(negedge clk);
        cmd_wr = 1'b1; col_in = 8'h90; dq_in = 8'hC0;
        #1;
        check("R5 susp beat0", int'(arr_col), 8'h90);
        @(negedge clk);
        cmd_wr = 1'b0; dq_in = 8'hC1;
        #1;
        check("R5 susp beat1", int'(arr_col), 8'h91);
        cke = 1'b0;
        @(negedge clk);
        dq_in = 8'hEE; cmd_wr = 1'b1; col_in = 8'hB0;
        #1;
        check("R9 no write", int'(arr_wr), 0);
        cke = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0; dq_in = 8'hC2;
        #1;
        check("R10 beat2 col", int'(arr_col), 8'h92);
        check("R10 beat2 wr", int'(arr_wr), 1);
        @(negedge clk);
        dq_in = 8'hC3;
        #1;
        check("R10 beat3 col", int'(arr_col), 8'h93);
        @(negedge clk);
        #1;
        check("R9 burst end", int'(arr_wr), 0);
        check("R9 ignored cmd", int'(mem[8'hB0]), int'(8'(8'hB0 * 5 + 1)));
        check("R9 data", int'(mem[8'h92]), 8'hC2);

        // R9: command on suspended edge while idle
        @(negedge clk);
        cke = 1'b0;
        @(negedge clk);
        cmd_rd = 1'b1; col_in = 8'h10; cke = 1'b1;
        @(negedge clk);
        cmd_rd = 1'b0;
        check("R9 idle rd", int'(arr_rd), 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R9 idle oe", int'(dq_oe), 0);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule